// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

Two independent ports share one array of words. Each port has its own clock, an asynchronous reset for its control registers, and a burst address counter. On each rising edge the counter can be cleared, loaded from the external address, stepped by one, or held. The access for that edge uses the counter's new value. Burst transfers therefore need only one external address, followed by count-enable edges. Reads and writes happen only when the port is selected by its two chip-select inputs. The counter keeps working while the port is deselected.

Each port reads in one of two latencies, chosen by a mode input. In flow-through mode the word is presented during the cycle after its address edge. In pipelined mode it is presented one cycle later. The output flag `rvalid` takes the place of a tri-state drive enable. It is gated at once by the output-enable input, and while it is low the data bus reads 0. The read stream has no ready input and cannot be stalled: a word is presented for exactly one cycle and any consumer must take it then.

The array has 2^ADDR_W words of DATA_W bits. Set ADDR_W to 14 for a 16384-word part. With HALF_DEPTH set, only half the words exist and the top address bit is ignored. The counter keeps its full width.

Top module: `twin_port_burst_ram`

## Requirements
- R1: When `cnt_clr_n` is low at a rising edge, the internal address becomes 0. This holds whatever `ld_n`, `cnt_en_n`, the chip selects or `addr` are.
- R2: When `cnt_clr_n` is high and `ld_n` is low at an edge, the internal address becomes `addr`, and that edge's access uses it.
- R3: When `cnt_clr_n` and `ld_n` are high and `cnt_en_n` is low, the internal address steps by one, wrapping from 2^ADDR_W-1 to 0. It also steps while the port is deselected.
- R4: When `cnt_clr_n`, `ld_n` and `cnt_en_n` are all high, the internal address is kept and `addr` has no effect.
- R5: A port is selected only when `cs0_n` is low and `cs1` is high. While selected, `wr_n` low writes `wdata` at that edge and `wr_n` high reads. A deselected edge writes nothing and yields no valid output.
- R6: With `pipe` low (flow-through), `rvalid`/`rdata` for a read edge are presented from that edge until the next one.
- R7: With `pipe` high (pipelined), they are presented one edge later. The valid flag of a following write or deselect edge likewise drops one edge later.
- R8: While `oe_n` is high, `rvalid` is 0 and `rdata` is 0 without waiting for a clock. Lowering `oe_n` shows the pending word at once.
- R9: A word written by one port is read back by the other. A read on one port at the same edge as a write to the same word on the other port returns either the old or the new word.
- R10: With HALF_DEPTH=1, address bit ADDR_W-1 is ignored, so addresses that differ only in it reach the same word.
- R11: After reset, `rvalid` is 0, `rdata` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| arst_a_n | input | 1 | Port A asynchronous reset of control registers, active low |
| addr_a | input | ADDR_W | Port A external address |
| ld_n_a | input | 1 | Port A load external address, active low |
| cnt_en_n_a | input | 1 | Port A counter step enable, active low |
| cnt_clr_n_a | input | 1 | Port A counter clear, active low |
| cs0_n_a | input | 1 | Port A chip select, active low |
| cs1_a | input | 1 | Port A chip select, active high |
| wr_n_a | input | 1 | Port A 0 = write, 1 = read |
| oe_n_a | input | 1 | Port A output enable, active low |
| pipe_a | input | 1 | Port A 0 = flow-through, 1 = pipelined |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A read data, 0 when not valid |
| rvalid_a | output | 1 | Port A read word valid / drive flag |
| clk_b | input | 1 | Port B clock |
| arst_b_n | input | 1 | Port B asynchronous reset of control registers, active low |
| addr_b | input | ADDR_W | Port B external address |
| ld_n_b | input | 1 | Port B load external address, active low |
| cnt_en_n_b | input | 1 | Port B counter step enable, active low |
| cnt_clr_n_b | input | 1 | Port B counter clear, active low |
| cs0_n_b | input | 1 | Port B chip select, active low |
| cs1_b | input | 1 | Port B chip select, active high |
| wr_n_b | input | 1 | Port B 0 = write, 1 = read |
| oe_n_b | input | 1 | Port B output enable, active low |
| pipe_b | input | 1 | Port B 0 = flow-through, 1 = pipelined |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B read data, 0 when not valid |
| rvalid_b | output | 1 | Port B read word valid / drive flag |

## Verification
Two functions can land on the same edge: a write through one port and a read of the same word through the other. The bench provokes this by loading the same address on both ports at one edge, port A writing and port B reading in flow-through mode. It accepts either the previous or the freshly written word, then re-reads on the next edge and expects the new word. A second coincidence also lands on one edge: a counter step and a deselected write request. The bench checks that the step happens while the word stays untouched.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  typedef enum logic [1:0] {
    CTR_HOLD  = 2'd0,
    CTR_STEP  = 2'd1,
    CTR_LOAD  = 2'd2,
    CTR_CLEAR = 2'd3
  } ctr_op_e;

endpackage

// File: rtl/dpb_addr_ctr.sv
module dpb_addr_ctr
  import dpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          ld_n,
  input  logic          en_n,
  input  logic          clr_n,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] q
);

  ctr_op_e op;

  always_comb begin
    if (!clr_n)     op = CTR_CLEAR;
    else if (!ld_n) op = CTR_LOAD;
    else if (!en_n) op = CTR_STEP;
    else            op = CTR_HOLD;
  end

  always_comb begin
    unique case (op)
      CTR_CLEAR: nxt = '0;
      CTR_LOAD:  nxt = ext_addr;
      CTR_STEP:  nxt = q + AW'(1);
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/dpb_port_ctl.sv
module dpb_port_ctl
  import dpb_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs0_n,
  input  logic          cs1,
  input  logic          wr_n,
  input  logic          oe_n,
  input  out_mode_e     mode,
  input  logic [DW-1:0] mem_rd,
  output logic          wr_en,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic          sel;
  logic          rd_now;
  logic          rd_q;
  logic          pv_q;
  logic [DW-1:0] pd_q;
  logic          stage_v;
  logic [DW-1:0] stage_d;

  assign sel    = !cs0_n && cs1;
  assign wr_en  = sel && !wr_n;
  assign rd_now = sel && wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      rd_q <= rd_now;
      pv_q <= rd_q;
      pd_q <= mem_rd;
    end
  end

  always_comb begin
    if (mode == OUT_PIPE) begin
      stage_v = pv_q;
      stage_d = pd_q;
    end else begin
      stage_v = rd_q;
      stage_d = mem_rd;
    end
  end

  assign rvalid = stage_v && !oe_n;
  assign rdata  = rvalid ? stage_d : '0;

endmodule

// File: rtl/dpb_xor_bank.sv
module dpb_xor_bank #(
  parameter int IW  = 10,
  parameter int DW  = 9,
  parameter int NRD = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [IW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][IW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);

  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = cells[raddr[g]];
  end

endmodule

// File: rtl/twin_port_burst_ram.sv
module twin_port_burst_ram
  import dpb_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 9,
  parameter bit HALF_DEPTH = 1'b0
) (
  input  logic              clk_a,
  input  logic              arst_a_n,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              ld_n_a,
  input  logic              cnt_en_n_a,
  input  logic              cnt_clr_n_a,
  input  logic              cs0_n_a,
  input  logic              cs1_a,
  input  logic              wr_n_a,
  input  logic              oe_n_a,
  input  logic              pipe_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rdata_a,
  output logic              rvalid_a,
  input  logic              clk_b,
  input  logic              arst_b_n,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              ld_n_b,
  input  logic              cnt_en_n_b,
  input  logic              cnt_clr_n_b,
  input  logic              cs0_n_b,
  input  logic              cs1_b,
  input  logic              wr_n_b,
  input  logic              oe_n_b,
  input  logic              pipe_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rdata_b,
  output logic              rvalid_b
);

  localparam int IW  = HALF_DEPTH ? ADDR_W - 1 : ADDR_W;
  localparam int NRD = 3;

  logic [ADDR_W-1:0] nxt_a, cnt_q_a;
  logic [ADDR_W-1:0] nxt_b, cnt_q_b;
  logic [IW-1:0]     idx_a, idx_b, widx_a, widx_b;
  logic              wr_en_a, wr_en_b;
  logic [DATA_W-1:0] word_a, word_b;

  logic [NRD-1:0][IW-1:0]     ra_addr, rb_addr;
  logic [NRD-1:0][DATA_W-1:0] ra_data, rb_data;

  dpb_addr_ctr #(.AW(ADDR_W)) u_ctr_a (
    .clk(clk_a), .rst_n(arst_a_n), .ext_addr(addr_a), .ld_n(ld_n_a),
    .en_n(cnt_en_n_a), .clr_n(cnt_clr_n_a), .nxt(nxt_a), .q(cnt_q_a)
  );

  dpb_addr_ctr #(.AW(ADDR_W)) u_ctr_b (
    .clk(clk_b), .rst_n(arst_b_n), .ext_addr(addr_b), .ld_n(ld_n_b),
    .en_n(cnt_en_n_b), .clr_n(cnt_clr_n_b), .nxt(nxt_b), .q(cnt_q_b)
  );

  // Access index of the current cycle and write index of the coming edge.
  assign idx_a  = cnt_q_a[IW-1:0];
  assign idx_b  = cnt_q_b[IW-1:0];
  assign widx_a = nxt_a[IW-1:0];
  assign widx_b = nxt_b[IW-1:0];

  // Read slot 0: port A word, slot 1: port B word, slot 2: the other port's write index.
  assign ra_addr = {widx_b, idx_b, idx_a};
  assign rb_addr = {widx_a, idx_b, idx_a};

  dpb_xor_bank #(.IW(IW), .DW(DATA_W), .NRD(NRD)) u_bank_a (
    .clk(clk_a), .we(wr_en_a), .waddr(widx_a),
    .wdata(wdata_a ^ rb_data[2]), .raddr(ra_addr), .rdata(ra_data)
  );

  dpb_xor_bank #(.IW(IW), .DW(DATA_W), .NRD(NRD)) u_bank_b (
    .clk(clk_b), .we(wr_en_b), .waddr(widx_b),
    .wdata(wdata_b ^ ra_data[2]), .raddr(rb_addr), .rdata(rb_data)
  );

  assign word_a = ra_data[0] ^ rb_data[0];
  assign word_b = ra_data[1] ^ rb_data[1];

  dpb_port_ctl #(.DW(DATA_W)) u_out_a (
    .clk(clk_a), .rst_n(arst_a_n), .cs0_n(cs0_n_a), .cs1(cs1_a),
    .wr_n(wr_n_a), .oe_n(oe_n_a), .mode(out_mode_e'(pipe_a)),
    .mem_rd(word_a), .wr_en(wr_en_a), .rdata(rdata_a), .rvalid(rvalid_a)
  );

  dpb_port_ctl #(.DW(DATA_W)) u_out_b (
    .clk(clk_b), .rst_n(arst_b_n), .cs0_n(cs0_n_b), .cs1(cs1_b),
    .wr_n(wr_n_b), .oe_n(oe_n_b), .mode(out_mode_e'(pipe_b)),
    .mem_rd(word_b), .wr_en(wr_en_b), .rdata(rdata_b), .rvalid(rvalid_b)
  );

endmodule

// File: rtl/dpb_chk.sv
module dpb_chk #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input logic          clk_a,
  input logic          arst_a_n,
  input logic [AW-1:0] addr_a,
  input logic          ld_n_a,
  input logic          cnt_en_n_a,
  input logic          cnt_clr_n_a,
  input logic          cs0_n_a,
  input logic          cs1_a,
  input logic          wr_n_a,
  input logic          oe_n_a,
  input logic          pipe_a,
  input logic [DW-1:0] rdata_a,
  input logic          rvalid_a,
  input logic [AW-1:0] cnt_q_a,
  input logic          clk_b,
  input logic          arst_b_n,
  input logic          cs0_n_b,
  input logic          cs1_b,
  input logic          wr_n_b,
  input logic          pipe_b,
  input logic          rvalid_b
);

  // R1
  a_r1_clear_wins: assert property (@(posedge clk_a) disable iff (!arst_a_n)
    !cnt_clr_n_a |=> (cnt_q_a == '0));

  // R2
  a_r2_load_addr: assert property (@(posedge clk_a) disable iff (!arst_a_n)
    (cnt_clr_n_a && !ld_n_a) |=> (cnt_q_a == $past(addr_a)));

  // R3
  a_r3_step_wraps: assert property (@(posedge clk_a) disable iff (!arst_a_n)
    (cnt_clr_n_a && ld_n_a && !cnt_en_n_a) |=> (cnt_q_a == AW'($past(cnt_q_a) + 1'b1)));

  // R4
  a_r4_hold_addr: assert property (@(posedge clk_a) disable iff (!arst_a_n)
    (cnt_clr_n_a && ld_n_a && cnt_en_n_a) |=> $stable(cnt_q_a));

  // R6
  a_r6_flow_source: assert property (@(posedge clk_a) disable iff (!arst_a_n)
    (rvalid_a && !pipe_a) |-> $past(!cs0_n_a && cs1_a && wr_n_a));

  // R7
  a_r7_pipe_source: assert property (@(posedge clk_b) disable iff (!arst_b_n)
    (rvalid_b && pipe_b) |-> $past(!cs0_n_b && cs1_b && wr_n_b, 2));

  // R8
  a_r8_oe_gate: assert property (@(posedge clk_a) disable iff (!arst_a_n)
    oe_n_a |-> (!rvalid_a && (rdata_a == '0)));

endmodule

bind twin_port_burst_ram dpb_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk_a(clk_a), .arst_a_n(arst_a_n), .addr_a(addr_a), .ld_n_a(ld_n_a),
  .cnt_en_n_a(cnt_en_n_a), .cnt_clr_n_a(cnt_clr_n_a), .cs0_n_a(cs0_n_a),
  .cs1_a(cs1_a), .wr_n_a(wr_n_a), .oe_n_a(oe_n_a), .pipe_a(pipe_a),
  .rdata_a(rdata_a), .rvalid_a(rvalid_a), .cnt_q_a(cnt_q_a),
  .clk_b(clk_b), .arst_b_n(arst_b_n), .cs0_n_b(cs0_n_b), .cs1_b(cs1_b),
  .wr_n_b(wr_n_b), .pipe_b(pipe_b), .rvalid_b(rvalid_b)
);

// File: tb/twin_port_burst_ram_tb_top.sv
module twin_port_burst_ram_tb_top;

  localparam int AW = 10;
  localparam int DW = 9;
  localparam int NV = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;

  logic [AW-1:0] a_addr, b_addr, h_addr;
  logic [DW-1:0] a_wd, b_wd, h_wd;
  logic a_ld_n, a_en_n, a_clr_n, a_cs0_n, a_cs1, a_wr_n, a_oe_n, a_pipe;
  logic b_ld_n, b_en_n, b_clr_n, b_cs0_n, b_cs1, b_wr_n, b_oe_n, b_pipe;
  logic h_ld_n, h_cs1, h_wr_n;
  logic [DW-1:0] a_rd, b_rd, h_rd, hb_rd;
  logic a_rv, b_rv, h_rv, hb_rv;

  twin_port_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .HALF_DEPTH(1'b0)) dut_i (
    .clk_a(clk), .arst_a_n(rst_n), .addr_a(a_addr), .ld_n_a(a_ld_n),
    .cnt_en_n_a(a_en_n), .cnt_clr_n_a(a_clr_n), .cs0_n_a(a_cs0_n), .cs1_a(a_cs1),
    .wr_n_a(a_wr_n), .oe_n_a(a_oe_n), .pipe_a(a_pipe), .wdata_a(a_wd),
    .rdata_a(a_rd), .rvalid_a(a_rv),
    .clk_b(clk), .arst_b_n(rst_n), .addr_b(b_addr), .ld_n_b(b_ld_n),
    .cnt_en_n_b(b_en_n), .cnt_clr_n_b(b_clr_n), .cs0_n_b(b_cs0_n), .cs1_b(b_cs1),
    .wr_n_b(b_wr_n), .oe_n_b(b_oe_n), .pipe_b(b_pipe), .wdata_b(b_wd),
    .rdata_b(b_rd), .rvalid_b(b_rv)
  );

  twin_port_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .HALF_DEPTH(1'b1)) dut_h (
    .clk_a(clk), .arst_a_n(rst_n), .addr_a(h_addr), .ld_n_a(h_ld_n),
    .cnt_en_n_a(1'b1), .cnt_clr_n_a(1'b1), .cs0_n_a(1'b0), .cs1_a(h_cs1),
    .wr_n_a(h_wr_n), .oe_n_a(1'b0), .pipe_a(1'b0), .wdata_a(h_wd),
    .rdata_a(h_rd), .rvalid_a(h_rv),
    .clk_b(clk), .arst_b_n(rst_n), .addr_b('0), .ld_n_b(1'b1),
    .cnt_en_n_b(1'b1), .cnt_clr_n_b(1'b1), .cs0_n_b(1'b1), .cs1_b(1'b0),
    .wr_n_b(1'b1), .oe_n_b(1'b0), .pipe_b(1'b0), .wdata_b('0),
    .rdata_b(hb_rd), .rvalid_b(hb_rv)
  );

  // {clr_n, ld_n, en_n, wr_n, addr[9:0], wdata[8:0], exp_valid, exp_data[8:0]}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 10'd9,   9'h03C, 1'b0, 9'h000},
    {1'b1, 1'b0, 1'b1, 1'b0, 10'd5,   9'h1A5, 1'b0, 9'h000},
    {1'b1, 1'b1, 1'b0, 1'b0, 10'd0,   9'h0F0, 1'b0, 9'h000},
    {1'b1, 1'b1, 1'b0, 1'b0, 10'd0,   9'h155, 1'b0, 9'h000},
    {1'b1, 1'b0, 1'b1, 1'b1, 10'd5,   9'h000, 1'b1, 9'h1A5},
    {1'b1, 1'b1, 1'b0, 1'b1, 10'd0,   9'h000, 1'b1, 9'h0F0},
    {1'b1, 1'b1, 1'b1, 1'b1, 10'h3FF, 9'h000, 1'b1, 9'h0F0},
    {1'b1, 1'b1, 1'b0, 1'b1, 10'd0,   9'h000, 1'b1, 9'h155},
    {1'b0, 1'b0, 1'b0, 1'b1, 10'd7,   9'h000, 1'b1, 9'h03C},
    {1'b1, 1'b0, 1'b1, 1'b0, 10'h3FF, 9'h111, 1'b0, 9'h000},
    {1'b1, 1'b1, 1'b0, 1'b0, 10'd0,   9'h0AA, 1'b0, 9'h000},
    {1'b1, 1'b0, 1'b1, 1'b1, 10'h3FF, 9'h000, 1'b1, 9'h111},
    {1'b1, 1'b1, 1'b0, 1'b1, 10'd0,   9'h000, 1'b1, 9'h0AA}
  };

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic a_drive(input bit clr_n, input bit ld_n, input bit en_n, input bit sel,
                         input bit wr_n, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    a_clr_n = clr_n; a_ld_n = ld_n; a_en_n = en_n;
    a_cs0_n = !sel;  a_cs1  = sel;  a_wr_n = wr_n;
    a_addr  = ad;    a_wd   = wd;
  endtask

  task automatic b_drive(input bit ld_n, input bit en_n, input bit sel,
                         input bit wr_n, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    b_clr_n = 1'b1; b_ld_n = ld_n; b_en_n = en_n;
    b_cs0_n = !sel; b_cs1  = sel;  b_wr_n = wr_n;
    b_addr  = ad;   b_wd   = wd;
  endtask

  initial begin
    rst_n  = 1'b0;
    a_drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
    b_drive(1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
    a_oe_n = 1'b0; a_pipe = 1'b0;
    b_oe_n = 1'b0; b_pipe = 1'b1;
    h_addr = '0; h_wd = '0; h_ld_n = 1'b1; h_cs1 = 1'b0; h_wr_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state
    chk(!a_rv && a_rd == '0, "R11 port A idle after reset", {a_rv, a_rd}, '0);
    chk(!b_rv && b_rd == '0, "R11 port B idle after reset", {b_rv, b_rd}, '0);
    rst_n = 1'b1;
    step();

    // Vector table on port A, flow-through, exercising R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      a_drive(v[32], v[31], v[30], 1'b1, v[29], v[28:19], v[18:10]);
      step();
      chk({a_rv, a_rd} == v[9:0], $sformatf("R6 vector %0d (counter R1 R2 R3 R4)", i),
          {a_rv, a_rd}, v[9:0]);
    end

    // R7: pipelined latency and late turn-off on port B
    a_drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
    b_drive(1'b0, 1'b1, 1'b1, 1'b1, 10'd5, '0);
    step();
    chk(!b_rv, "R7 pipelined read not yet shown", {b_rv, b_rd}, '0);
    b_drive(1'b0, 1'b1, 1'b1, 1'b0, 10'd6, 9'h0F0);
    step();
    chk(b_rv && b_rd == 9'h1A5, "R7 pipelined read one edge later", {b_rv, b_rd}, {1'b1, 9'h1A5});
    b_drive(1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
    step();
    chk(!b_rv && b_rd == '0, "R7 write edge drops valid one edge later", {b_rv, b_rd}, '0);

    // R5 with R3: deselected edge still steps counter, writes nothing
    a_drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5, '0);
    step();
    chk(a_rv && a_rd == 9'h1A5, "R5 selected read", {a_rv, a_rd}, {1'b1, 9'h1A5});
    a_drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd0, 9'h1FF);
    step();
    chk(!a_rv && a_rd == '0, "R5 deselected edge gives no valid", {a_rv, a_rd}, '0);
    a_drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, '0);
    step();
    chk(a_rv && a_rd == 9'h0F0, "R3 deselected step reached word 6, R5 no write",
        {a_rv, a_rd}, {1'b1, 9'h0F0});

    // R8: output enable gates asynchronously
    a_oe_n = 1'b1;
    step();
    chk(!a_rv && a_rd == '0, "R8 oe_n high blanks output", {a_rv, a_rd}, '0);
    a_oe_n = 1'b0;
    #1;
    chk(a_rv && a_rd == 9'h0F0, "R8 oe_n low shows word without clock", {a_rv, a_rd}, {1'b1, 9'h0F0});

    // R9: cross-port sharing and same-edge read/write collision
    a_drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd20, 9'h011);
    step();
    b_pipe = 1'b0;
    a_drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd20, 9'h122);
    b_drive(1'b0, 1'b1, 1'b1, 1'b1, 10'd20, '0);
    step();
    chk(b_rv && (b_rd == 9'h011 || b_rd == 9'h122), "R9 same-edge read gives old or new",
        {b_rv, b_rd}, {1'b1, 9'h122});
    a_drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
    b_drive(1'b1, 1'b1, 1'b1, 1'b1, 10'd0, '0);
    step();
    chk(b_rv && b_rd == 9'h122, "R9 other port reads written word", {b_rv, b_rd}, {1'b1, 9'h122});

    // R10: half-depth instance ignores the top address bit
    h_cs1 = 1'b1; h_ld_n = 1'b0; h_wr_n = 1'b0; h_addr = 10'h205; h_wd = 9'h0C3;
    step();
    h_wr_n = 1'b1; h_addr = 10'h005;
    step();
    chk(h_rv && h_rd == 9'h0C3, "R10 top address bit ignored", {h_rv, h_rd}, {1'b1, 9'h0C3});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule